// File: doc/BRIEF.md
# Four-Channel Gain Mixer with Peak Hold

This block merges the current sample of four audio channels into one signed output word. Each channel's two's-complement 8-bit sample is scaled by that channel's unsigned 8-bit gain. The four scaled values are added, and the total is then scaled by an unsigned 8-bit master gain. The result is clamped to the output width and held in a register that loads only on cycles where the sample-rate strobe `tick_i` is high.

For each channel the block also keeps a peak-hold byte. It holds the largest magnitude of that channel's scaled value seen on strobe cycles. The host sees the held value on `peak_o`. It pulses the channel's read-clear line in the same cycle it takes the value, and the byte restarts from zero. A strobe that lands in the same cycle as a clear is not lost: it becomes the first value after the clear. The asynchronous reset input is released synchronously inside the block.

Top module: `quad_gain_mixer`

## Requirements
- R1: After reset, `mix_o` is 0 and every peak byte is 0.
- R2: A channel's scaled value is floor(sample × gain / 256). The sample is two's complement. The gain is unsigned, with 0 giving silence and 255 the largest gain.
- R3: On a strobe, the new mix is floor((sum of the four scaled values) × master / 256), clamped to the signed range of `mix_o` (−512..511 with the default 10-bit width).
- R4: `mix_o` changes only on the clock edge that follows a cycle with `tick_i` high. It holds its value otherwise.
- R5: On a strobe, a channel's peak byte becomes the larger of its held value and the magnitude of its scaled value. A magnitude of 128 is reported as 128.
- R6: While `peak_rd_i[c]` is high, `peak_o` shows the held byte. On the next edge, with no strobe in that cycle, the byte becomes 0.
- R7: When a read-clear and a strobe happen in the same cycle, the peak byte becomes the magnitude from that strobe alone.
- R8: Channel c uses bits [8c+7:8c] of `sample_i`, `vol_i` and `peak_o`, and bit c of `peak_rd_i`. A read-clear on one channel leaves the other channels' peaks unchanged.
- R9: Samples and gains presented while `tick_i` is low change neither `mix_o` nor any peak byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample-rate strobe, acts as the clock enable |
| sample_i | input | 32 | Four signed 8-bit samples, channel 0 in the low byte |
| vol_i | input | 32 | Four unsigned 8-bit channel gains |
| master_i | input | 8 | Unsigned master gain |
| peak_rd_i | input | 4 | Per-channel peak read-clear |
| mix_o | output | 10 | Registered signed mix |
| peak_o | output | 32 | Four peak-hold bytes |

## Verification
The bench targets the rounding of negative products. A design that truncates toward zero gives −1 × 1 / 256 as 0 instead of −1. It also drives the full-scale negative corner, where the magnitude 128 must not wrap to 0 and the four-channel sum of −512 must not overflow before the master gain is applied. Clears are issued alone, together with a strobe, and on a single channel among active ones. A design that clears after capturing, or that clears every channel, ends up with a wrong byte. Long quiet stretches with `tick_i` low and busy inputs expose any register that loads without the strobe.

// File: rtl/quad_gain_mixer_pkg.sv
package quad_gain_mixer_pkg;

  // Magnitude of a two's-complement value, returned unsigned at the same width.
  function automatic logic [7:0] mag8(input logic [7:0] v);
    mag8 = v[7] ? (~v + 8'd1) : v;
  endfunction

endpackage

// File: rtl/qgm_chan_scale.sv
module qgm_chan_scale #(
  parameter int SW = 8,
  parameter int VW = 8
) (
  input  logic [SW-1:0] sample_i,
  input  logic [VW-1:0] vol_i,
  output logic [SW-1:0] scaled_o,
  output logic [SW-1:0] mag_o
);

  logic signed [SW+VW-1:0] prod;

  always_comb begin
    prod     = $signed(sample_i) * $signed({1'b0, vol_i});
    scaled_o = prod[SW+VW-1:VW];
    mag_o    = scaled_o[SW-1] ? (~scaled_o + SW'(1)) : scaled_o;
  end

  // R2
  always_comb begin
    if (vol_i == '0) begin
      zero_gain_chk: assert (scaled_o == '0);
    end
  end

endmodule

// File: rtl/qgm_peak_hold.sv
module qgm_peak_hold #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          rd_i,
  input  logic [PW-1:0] mag_i,
  output logic [PW-1:0] peak_o
);

  logic [PW-1:0] peak_q;
  logic [PW-1:0] peak_d;
  logic [PW-1:0] base;

  always_comb begin
    base   = rd_i ? '0 : peak_q;
    peak_d = base;
    if (tick_i && (mag_i > base)) begin
      peak_d = mag_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q <= '0;
    end else begin
      peak_q <= peak_d;
    end
  end

  assign peak_o = peak_q;

  // R9
  peak_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !rd_i) |=> $stable(peak_q));
  // R6
  peak_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !tick_i) |=> (peak_q == '0));
  // R5
  peak_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !rd_i) |=> (peak_q >= $past(mag_i)) && (peak_q >= $past(peak_q)));
  // R7
  peak_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && rd_i) |=> (peak_q == $past(mag_i)));

endmodule

// File: rtl/qgm_mix_core.sv
module qgm_mix_core #(
  parameter int NCH = 4,
  parameter int SW  = 8,
  parameter int VW  = 8,
  parameter int OW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [NCH*SW-1:0] scaled_i,
  input  logic [VW-1:0]     master_i,
  output logic [OW-1:0]     mix_o
);

  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SUMW = SW + CW;
  localparam int GPW  = SUMW + VW;

  logic signed [SUMW-1:0] acc;
  logic signed [GPW-1:0]  gprod;
  logic signed [SUMW-1:0] gained;
  logic [OW-1:0]          sat;
  logic [OW-1:0]          mix_q;
  logic [OW-1:0]          mix_d;

  always_comb begin
    acc = '0;
    for (int c = 0; c < NCH; c++) begin
      acc = acc + SUMW'($signed(scaled_i[c*SW +: SW]));
    end
    gprod  = acc * $signed({1'b0, master_i});
    gained = gprod[GPW-1:VW];
  end

  generate
    if (OW >= SUMW) begin : g_wide
      assign sat = OW'(gained);
    end else begin : g_clamp
      localparam logic signed [SUMW-1:0] HI = SUMW'((1 << (OW-1)) - 1);
      localparam logic signed [SUMW-1:0] LO = -HI - SUMW'(1);
      always_comb begin
        if (gained > HI)      sat = HI[OW-1:0];
        else if (gained < LO) sat = LO[OW-1:0];
        else                  sat = gained[OW-1:0];
      end
    end
  endgenerate

  always_comb begin
    mix_d = tick_i ? sat : mix_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mix_q <= '0;
    end else begin
      mix_q <= mix_d;
    end
  end

  assign mix_o = mix_q;

  // R4
  mix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(mix_q));
  // R3
  mix_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && master_i == '0) |=> (mix_q == '0));

endmodule

// File: rtl/quad_gain_mixer.sv
module quad_gain_mixer #(
  parameter int NCH = 4,
  parameter int SW  = 8,
  parameter int VW  = 8,
  parameter int OW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [NCH*SW-1:0] sample_i,
  input  logic [NCH*VW-1:0] vol_i,
  input  logic [VW-1:0]     master_i,
  input  logic [NCH-1:0]    peak_rd_i,
  output logic [OW-1:0]     mix_o,
  output logic [NCH*SW-1:0] peak_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NCH*SW-1:0] scaled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [SW-1:0] mag;

      qgm_chan_scale #(.SW(SW), .VW(VW)) u_scale (
        .sample_i (sample_i[c*SW +: SW]),
        .vol_i    (vol_i[c*VW +: VW]),
        .scaled_o (scaled[c*SW +: SW]),
        .mag_o    (mag)
      );

      qgm_peak_hold #(.PW(SW)) u_peak (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .tick_i (tick_i),
        .rd_i   (peak_rd_i[c]),
        .mag_i  (mag),
        .peak_o (peak_o[c*SW +: SW])
      );
    end
  endgenerate

  qgm_mix_core #(.NCH(NCH), .SW(SW), .VW(VW), .OW(OW)) u_mix (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick_i   (tick_i),
    .scaled_i (scaled),
    .master_i (master_i),
    .mix_o    (mix_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |=> !rst_int_n || (mix_o == '0 && peak_o == '0));

endmodule

// File: tb/quad_gain_mixer_tb.sv
`timescale 1ns/1ps
module quad_gain_mixer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic [31:0] sample_i;
  logic [31:0] vol_i;
  logic [7:0]  master_i;
  logic [3:0]  peak_rd_i;
  logic [9:0]  mix_o;
  logic [31:0] peak_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int exp_mix;
  int exp_peak[4];

  always #2.5 clk = ~clk;

  quad_gain_mixer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sample_i(sample_i),
    .vol_i(vol_i), .master_i(master_i), .peak_rd_i(peak_rd_i),
    .mix_o(mix_o), .peak_o(peak_o)
  );

  function automatic int scl(int s, int v);
    return (s * v) >>> 8;
  endfunction

  task automatic compare(string req);
    int got;
    checks++;
    got = $signed(mix_o);
    if (got != exp_mix) begin
      failures++;
      $display("FAIL %s mix actual=%0d expected=%0d", req, got, exp_mix);
    end
    for (int c = 0; c < 4; c++) begin
      checks++;
      if (int'(peak_o[c*8 +: 8]) != exp_peak[c]) begin
        failures++;
        $display("FAIL %s peak%0d actual=%0d expected=%0d", req, c,
                 peak_o[c*8 +: 8], exp_peak[c]);
      end
    end
  endtask

  // Called just after a falling edge: drive, advance the model, check after the next edge.
  task automatic step(bit tk, int s[4], int v[4], int m, bit [3:0] rd, string req);
    int sum;
    int mag;
    int g;
    tick_i = tk; master_i = m[7:0]; peak_rd_i = rd;
    sum = 0;
    for (int c = 0; c < 4; c++) begin
      sample_i[c*8 +: 8] = s[c][7:0];
      vol_i[c*8 +: 8]    = v[c][7:0];
    end
    for (int c = 0; c < 4; c++) begin
      int sv;
      sv  = scl($signed(s[c][7:0]), v[c] & 255);
      sum += sv;
      mag = (sv < 0) ? -sv : sv;
      if (rd[c]) exp_peak[c] = tk ? mag : 0;
      else if (tk && mag > exp_peak[c]) exp_peak[c] = mag;
    end
    if (tk) begin
      g = (sum * (m & 255)) >>> 8;
      if (g > 511) g = 511;
      if (g < -512) g = -512;
      exp_mix = g;
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s[4];
    int v[4];
    rst_n = 1'b0; tick_i = 0; sample_i = '0; vol_i = '0; master_i = '0; peak_rd_i = '0;
    exp_mix = 0;
    for (int c = 0; c < 4; c++) exp_peak[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1");

    // R2: positive and negative rounding on one channel
    s = '{100, 0, 0, 0}; v = '{255, 0, 0, 0};
    step(1, s, v, 255, 4'b0000, "R2");
    s = '{-1, 0, 0, 0}; v = '{1, 0, 0, 0};
    step(1, s, v, 255, 4'b0000, "R2");
    s = '{-100, 50, 0, 0}; v = '{0, 0, 0, 0};
    step(1, s, v, 255, 4'b0000, "R2");

    // R3: full-scale corners and master gain
    s = '{-128, -128, -128, -128}; v = '{255, 255, 255, 255};
    step(1, s, v, 255, 4'b0000, "R3");
    s = '{127, 127, 127, 127};
    step(1, s, v, 255, 4'b0000, "R3");
    step(1, s, v, 0, 4'b0000, "R3");
    step(1, s, v, 128, 4'b0000, "R3");

    // R4 / R9: busy inputs without strobe
    s = '{-128, 90, -7, 33}; v = '{255, 200, 17, 3};
    step(0, s, v, 255, 4'b0000, "R4");
    step(0, s, v, 77, 4'b0000, "R9");

    // R6: clear alone, R8: one channel only
    step(0, s, v, 77, 4'b0010, "R6");
    step(0, s, v, 77, 4'b0000, "R8");
    step(0, s, v, 77, 4'b1111, "R6");

    // R7: clear together with a strobe
    s = '{20, -40, 60, -80}; v = '{255, 255, 255, 255};
    step(1, s, v, 200, 4'b0000, "R5");
    s = '{5, -5, 5, -5};
    step(1, s, v, 200, 4'b0101, "R7");

    // R8: distinct per-channel values
    s = '{10, -60, 110, -128}; v = '{255, 128, 64, 32};
    step(1, s, v, 255, 4'b1111, "R8");

    // R5: randomised traffic
    for (int k = 0; k < 4000; k++) begin
      int m;
      bit [3:0] rd;
      for (int c = 0; c < 4; c++) begin
        s[c] = int'($urandom_range(0, 255)) - 128;
        case ($urandom_range(0, 3))
          0: v[c] = 0;
          1: v[c] = 255;
          default: v[c] = int'($urandom_range(0, 255));
        endcase
      end
      m  = ($urandom_range(0, 4) == 0) ? 255 : int'($urandom_range(0, 255));
      rd = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) : 4'b0000;
      step($urandom_range(0, 2) != 0, s, v, m, rd, "R5");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule